// File: doc/BRIEF.md
# Glitch Offset and Length Sequencer

The sequencer supplies one delay offset and one pulse length for each fault-injection attempt. A downstream pulse timer asks for a pair and then takes it. Software programs four limits: an unsigned offset minimum and maximum, and a signed length minimum and maximum. From these limits the block decides how the length is formed. There is no separate mode register.

When the offset limits are equal and the length minimum is not negative, the length sweeps upward by one on each attempt and wraps to the minimum. When the length minimum is negative, the length follows a 12-bit analog sample, scaled against the length maximum. In every other case the length is drawn at random. In all three modes the offset is drawn at random from its range. The random values come from a 32-bit shift-register generator, which advances only when a value is drawn.

Top module: `glseq_top`

## Requirements
- R1: `cfg_ok` is 0 when `off_max` is below `off_min` (unsigned compare) or when `len_max` is below `len_min` (signed compare), and 1 otherwise.
- R2: A pair is accepted at a rising edge where `start` is 1, `out_valid` is 0 and `cfg_ok` is 1; `out_valid` is 1 from the following cycle. `start` has no effect while `out_valid` is 1 or `cfg_ok` is 0.
- R3: While `out_valid` is 1 and `ready` is 0, `out_offset`, `out_length` and `out_mode` do not change. `out_valid` returns to 0 after the first rising edge at which `ready` is 1.
- R4: `out_mode` reports how the length was formed: 1 (sweep) when `off_min == off_max` and `len_min >= 0`; otherwise 2 (knob) when `len_min < 0`; otherwise 0 (random).
- R5: The offset is `off_min + (r1 mod (off_max - off_min))`, where r1 is the first generator value drawn for the pair. When the offset range is zero the offset is `off_min`.
- R6: In random mode the length is `len_min + (r2 mod (len_max - len_min))`, where r2 is the second value drawn for the pair. When the length range is zero the length is `len_min`.
- R7: In sweep mode each length is one more than the previous sweep length. When the previous length equals `len_max`, the next length is `len_min`.
- R8: The sweep history resets to `len_min - 1` at reset and whenever the limits do not select sweep mode, so the first sweep length is `len_min`.
- R9: In knob mode the length is bits [43:12] of the 44-bit product of `knob_sample` and `len_max` read as unsigned. The sample is taken at the accept edge.
- R10: The generator is a right-shifting Galois register with feedback mask 0x80200003. It starts at a nonzero seed (default 0xACE12345). Each value drawn is one step: one step per pair in sweep and knob mode, two steps per pair in random mode, and no steps otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| off_min | input | 32 | Offset lower limit |
| off_max | input | 32 | Offset upper limit |
| len_min | input | 32 | Length lower limit, signed |
| len_max | input | 32 | Length upper limit, signed |
| knob_sample | input | 12 | Analog sample for knob mode |
| start | input | 1 | Request a new pair |
| ready | input | 1 | Consumer takes the held pair |
| cfg_ok | output | 1 | Limits form a valid set |
| out_valid | output | 1 | A pair is held on the outputs |
| out_offset | output | 32 | Offset of the held pair |
| out_length | output | 32 | Length of the held pair, signed |
| out_mode | output | 2 | How the length was formed (0 random, 1 sweep, 2 knob) |

## Verification
The assertions assume that the limits stay constant while a pair is held and that a request is made only with valid limits. Under these assumptions, the range and knob-bound checks compare the held outputs with the limits from the accept cycle. The bench follows the same discipline. It changes limits only in idle cycles with `out_valid` low. It tries invalid limits only to show that a request is refused. It changes the knob sample during a hold to confirm that the sample is captured at the accept edge and not tracked afterwards.

// File: rtl/glseq_pkg.sv
package glseq_pkg;
    localparam int VAL_W  = 32;
    localparam int ADC_W  = 12;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    typedef enum logic [1:0] {
        MODE_RAND  = 2'd0,
        MODE_SWEEP = 2'd1,
        MODE_KNOB  = 2'd2
    } glseq_mode_e;

    function automatic logic [VAL_W-1:0] lfsr_next(input logic [VAL_W-1:0] s,
                                                  input logic [VAL_W-1:0] mask);
        return s[0] ? ((s >> 1) ^ mask) : (s >> 1);
    endfunction

    function automatic glseq_mode_e pick_mode(input logic [VAL_W-1:0] omin,
                                              input logic [VAL_W-1:0] omax,
                                              input logic signed [VAL_W-1:0] lmin);
        if (omin == omax && lmin >= 0) return MODE_SWEEP;
        if (lmin < 0)                  return MODE_KNOB;
        return MODE_RAND;
    endfunction
endpackage

// File: rtl/glseq_lfsr.sv
module glseq_lfsr
    import glseq_pkg::*;
#(
    parameter int W = VAL_W,
    parameter logic [W-1:0] MASK = LFSR_MASK[W-1:0],
    parameter logic [W-1:0] SEED = 32'hACE1_2345
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_one,
    input  logic         adv_two,
    output logic [W-1:0] draw1_o,
    output logic [W-1:0] draw2_o,
    output logic [W-1:0] state_o
);
    localparam logic [W-1:0] SEED_SAFE = (SEED == '0) ? W'(1) : SEED;

    logic [W-1:0] state_q;

    assign draw1_o = lfsr_next(state_q, MASK);
    assign draw2_o = lfsr_next(draw1_o, MASK);
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst)          state_q <= SEED_SAFE;
        else if (adv_two) state_q <= draw2_o;
        else if (adv_one) state_q <= draw1_o;
    end

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/glseq_range_map.sv
module glseq_range_map
    import glseq_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  logic [W-1:0] min_i,
    input  logic [W-1:0] max_i,
    input  logic [W-1:0] rnd_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] span;

    always_comb begin
        span  = max_i - min_i;
        val_o = (span == '0) ? min_i : (min_i + (rnd_i % span));
    end
endmodule

// File: rtl/glseq_sweep.sv
module glseq_sweep
    import glseq_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_sweep,
    input  logic                step,
    input  logic signed [W-1:0] len_min,
    input  logic signed [W-1:0] len_max,
    output logic signed [W-1:0] next_o
);
    logic signed [W-1:0] hist_q;
    logic                fresh_q;
    logic signed [W-1:0] hist_eff;

    always_comb begin
        hist_eff = fresh_q ? (len_min - W'(1)) : hist_q;
        next_o   = (hist_eff == len_max) ? len_min : (hist_eff + W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !in_sweep) begin
            fresh_q <= 1'b1;
            hist_q  <= len_min - W'(1);
        end else if (step) begin
            fresh_q <= 1'b0;
            hist_q  <= next_o;
        end
    end

    // R8
    sweep_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_sweep && step && fresh_q && len_max >= len_min) |-> next_o == len_min);
endmodule

// File: rtl/glseq_top.sv
module glseq_top
    import glseq_pkg::*;
#(
    parameter int          W     = VAL_W,
    parameter int          AW    = ADC_W,
    parameter logic [W-1:0] SEED = 32'hACE1_2345
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        off_min,
    input  logic [W-1:0]        off_max,
    input  logic signed [W-1:0] len_min,
    input  logic signed [W-1:0] len_max,
    input  logic [AW-1:0]       knob_sample,
    input  logic                start,
    input  logic                ready,
    output logic                cfg_ok,
    output logic                out_valid,
    output logic [W-1:0]        out_offset,
    output logic signed [W-1:0] out_length,
    output logic [1:0]          out_mode
);
    localparam int PROD_W = W + AW;
    localparam int LANES  = 2;

    glseq_mode_e         cur_mode;
    glseq_mode_e         mode_q;
    logic                accept;
    logic [W-1:0]        draw1, draw2, lfsr_state;
    logic [W-1:0]        lane_min [LANES];
    logic [W-1:0]        lane_max [LANES];
    logic [W-1:0]        lane_rnd [LANES];
    logic [W-1:0]        lane_val [LANES];
    logic signed [W-1:0] sweep_len;
    logic [PROD_W-1:0]   knob_prod;
    logic [W-1:0]        knob_len;

    assign cfg_ok   = !(off_max < off_min) && !(len_max < len_min);
    assign cur_mode = pick_mode(off_min, off_max, len_min);
    assign accept   = start && !out_valid && cfg_ok;

    glseq_lfsr #(.W(W), .MASK(LFSR_MASK[W-1:0]), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .adv_one (accept && cur_mode != MODE_RAND),
        .adv_two (accept && cur_mode == MODE_RAND),
        .draw1_o (draw1),
        .draw2_o (draw2),
        .state_o (lfsr_state)
    );

    // lane 0 maps the offset, lane 1 the random-mode length
    assign lane_min[0] = off_min;
    assign lane_max[0] = off_max;
    assign lane_rnd[0] = draw1;
    assign lane_min[1] = len_min;
    assign lane_max[1] = len_max;
    assign lane_rnd[1] = draw2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        glseq_range_map #(.W(W)) u_map (
            .min_i (lane_min[g]),
            .max_i (lane_max[g]),
            .rnd_i (lane_rnd[g]),
            .val_o (lane_val[g])
        );
    end

    glseq_sweep #(.W(W)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .in_sweep (cur_mode == MODE_SWEEP),
        .step     (accept),
        .len_min  (len_min),
        .len_max  (len_max),
        .next_o   (sweep_len)
    );

    assign knob_prod = {{W{1'b0}}, knob_sample} * {{AW{1'b0}}, len_max};
    assign knob_len  = knob_prod[AW +: W];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_offset <= '0;
            out_length <= '0;
            mode_q     <= MODE_RAND;
        end else if (accept) begin
            out_valid  <= 1'b1;
            out_offset <= lane_val[0];
            mode_q     <= cur_mode;
            unique case (cur_mode)
                MODE_SWEEP: out_length <= sweep_len;
                MODE_KNOB:  out_length <= knob_len;
                default:    out_length <= lane_val[1];
            endcase
        end else if (out_valid && ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_mode = mode_q;

    // R2
    cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ok && !out_valid) |=> !out_valid);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ready) |=> out_valid && $stable(out_offset)
                                  && $stable(out_length) && $stable(out_mode));
    // R5
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_offset >= $past(off_min))
            && ($past(off_max) == $past(off_min) || out_offset < $past(off_max)));
    // R9
    knob_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && out_mode == MODE_KNOB) |->
            $unsigned(out_length) <= $unsigned($past(len_max)));
    // R10
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> $stable(lfsr_state));
endmodule

// File: tb/glseq_top_bench.sv
module glseq_top_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        off_min = 32'd100, off_max = 32'd1100;
    logic signed [31:0] len_min = 32'sd5, len_max = 32'sd40;
    logic [11:0]        knob_sample = '0;
    logic               start = 1'b0, ready = 1'b0;
    logic               cfg_ok, out_valid;
    logic [31:0]        out_offset;
    logic signed [31:0] out_length;
    logic [1:0]         out_mode;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [31:0]        m_lfsr = 32'hACE1_2345;
    logic signed [31:0] m_hist = '0;
    bit                 m_fresh = 1'b1;

    always #5 clk = ~clk;

    glseq_top u_glseq_top (
        .clk(clk), .rst(rst), .off_min(off_min), .off_max(off_max),
        .len_min(len_min), .len_max(len_max), .knob_sample(knob_sample),
        .start(start), .ready(ready), .cfg_ok(cfg_ok), .out_valid(out_valid),
        .out_offset(out_offset), .out_length(out_length), .out_mode(out_mode)
    );

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit m_is_sweep();
        return (off_min == off_max) && (len_min >= 0);
    endfunction

    task automatic set_cfg(input logic [31:0] omin, input logic [31:0] omax,
                           input logic signed [31:0] lmin, input logic signed [31:0] lmax);
        @(negedge clk);
        off_min = omin; off_max = omax; len_min = lmin; len_max = lmax;
        if (!m_is_sweep()) m_fresh = 1'b1;
    endtask

    task automatic pair(input bit hold_test, input string tag);
        logic [31:0] r, e_off, e_len;
        logic [1:0]  e_mode;
        logic signed [31:0] h;
        logic [63:0] p;
        r = m_step(m_lfsr); m_lfsr = r;
        e_off = (off_max == off_min) ? off_min : off_min + (r % (off_max - off_min));
        if (m_is_sweep()) begin
            e_mode = 2'd1;
            h = m_fresh ? (len_min - 1) : m_hist;
            e_len = (h == len_max) ? len_min : h + 1;
            m_hist = e_len; m_fresh = 1'b0;
        end else if (len_min < 0) begin
            e_mode = 2'd2;
            p = {52'b0, knob_sample} * {32'b0, len_max};
            e_len = p[43:12];
        end else begin
            e_mode = 2'd0;
            r = m_step(m_lfsr); m_lfsr = r;
            e_len = (len_max == len_min) ? len_min
                    : len_min + (r % (32'(len_max) - 32'(len_min)));
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk({tag, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R4 mode"}, 64'(out_mode), 64'(e_mode));
        chk({tag, " R5 offset"}, 64'(out_offset), 64'(e_off));
        chk({tag, " length"}, 64'(out_length), 64'(e_len));
        if (hold_test) begin
            start = 1'b1;
            knob_sample = knob_sample ^ 12'h5A5;
            @(negedge clk) start = 1'b0;
            knob_sample = knob_sample ^ 12'h5A5;
            chk({tag, " R3 hold valid"}, 64'(out_valid), 64'd1);
            chk({tag, " R3 hold offset"}, 64'(out_offset), 64'(e_off));
            chk({tag, " R3 hold length"}, 64'(out_length), 64'(e_len));
        end
        ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        chk({tag, " R3 release"}, 64'(out_valid), 64'd0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset valid", 64'(out_valid), 64'd0);
        chk("R1 ok cfg", 64'(cfg_ok), 64'd1);

        // R6 R10 random mode pairs, with a hold/ignored-start test (R2)
        for (int i = 0; i < 20; i++) pair(i == 3, "R6 R10 random");
        set_cfg(32'd0, 32'hFFFF_FFF0, 32'sd0, 32'sd1000);
        for (int i = 0; i < 10; i++) pair(1'b0, "R6 R10 wide");

        // R6 zero length range
        set_cfg(32'd10, 32'd20, 32'sd7, 32'sd7);
        for (int i = 0; i < 3; i++) pair(1'b0, "R6 zero range");

        // R7 R8 sweep with wrap
        set_cfg(32'd50, 32'd50, 32'sd3, 32'sd6);
        for (int i = 0; i < 9; i++) pair(i == 2, "R7 R8 sweep");
        set_cfg(32'd50, 32'd50, 32'sd9, 32'sd9);
        for (int i = 0; i < 3; i++) pair(1'b0, "R7 single");
        set_cfg(32'd10, 32'd20, 32'sd3, 32'sd6);
        pair(1'b0, "R8 leave sweep");
        set_cfg(32'd50, 32'd50, 32'sd3, 32'sd6);
        for (int i = 0; i < 2; i++) pair(1'b0, "R8 re-enter sweep");

        // R9 knob mode: every sample value, offset zero range (R5)
        set_cfg(32'd77, 32'd77, -32'sd1, 32'sd1000);
        for (int s = 0; s < 4096; s++) begin
            knob_sample = 12'(s);
            pair(s == 100, "R9 R5 knob sweep");
        end
        set_cfg(32'd0, 32'd300, -32'sd1, 32'sh7FFF_FFFF);
        for (int s = 0; s < 4; s++) begin
            knob_sample = (s == 0) ? 12'd4095 : (s == 1) ? 12'd2048 : (s == 2) ? 12'd1 : 12'd0;
            pair(1'b0, "R9 wide knob");
        end

        // R1 R2 invalid limits block requests
        set_cfg(32'd500, 32'd499, 32'sd0, 32'sd10);
        @(negedge clk);
        chk("R1 offset order", 64'(cfg_ok), 64'd0);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 refused", 64'(out_valid), 64'd0);
        set_cfg(32'd0, 32'd10, 32'sd5, -32'sd3);
        @(negedge clk);
        chk("R1 signed length order", 64'(cfg_ok), 64'd0);
        set_cfg(32'd0, 32'd10, -32'sd3, 32'sd5);
        @(negedge clk);
        chk("R1 signed ok", 64'(cfg_ok), 64'd1);

        // R10 generator unchanged by refused request
        set_cfg(32'd100, 32'd1100, 32'sd5, 32'sd40);
        for (int i = 0; i < 3; i++) pair(1'b0, "R10 after refuse");

        report();
    end
endmodule